// File: doc/BRIEF.md
# Four-Way Instruction Cache With Line Locking

This block is a read-only instruction cache for physical addresses. At the default parameters it holds 16 KB as 256 sets of four ways, and each line holds four 32-bit words. A fetch that hits returns its word combinationally in the cycle it is presented. A fetch that misses starts a four-beat burst on a simple memory port. The burst begins at the missed word and wraps within the line. That word is passed to the requester in the cycle it arrives, so the miss costs only the memory's own latency.

Victims are chosen by a true least-recently-used order kept per set. Ways whose lines are locked are skipped. A control port can lock or unlock the line holding an address, and it can invalidate the whole cache. Locking is how time-critical code is pinned in place. When every way of a set is locked, a miss is still served, but it leaves no copy behind.

Address fields at the default parameters: word select is bits [3:2], set index is bits [11:4], and tag is bits [31:12].

Top module: `icache_lock4`

## Requirements
- R1: After reset: `req_ready` is 1, `mem_req` is 0, `resp_valid` is 0, every line is invalid, and no line is locked.
- R2: While `req_ready` is 1, a fetch (`req_valid`=1, `ctl_valid`=0) whose tag matches a valid line in its set returns that word on `resp_data` with `resp_valid`=1 in the same cycle. `req_ready` stays 1.
- R3: A missing fetch leaves `resp_valid` at 0 in its request cycle. From the next cycle, `mem_req` is 1 and `req_ready` is 0. `mem_addr` carries the word-aligned missed address and holds steady until the fourth beat.
- R4: The four beats (`mem_rvalid`=1) carry words crit, crit+1, crit+2 and crit+3 modulo 4 of the line. They are stored so that later hits to any word of the line return the beat data.
- R5: On a fetch miss, the first beat raises `resp_valid` in that same cycle with `resp_data`=`mem_rdata`. No later beat raises `resp_valid`.
- R6: The cycle after the fourth beat, `mem_req` is 0 and `req_ready` is 1.
- R7: The victim is the least recently used unlocked way. Hits and fills make a way the most recent. From reset, or after an invalidate, the ways of a set fill in the order 0, 1, 2, 3.
- R8: `ctl_op`=01 (lock) on an address that hits sets that line's lock bit in one cycle. A locked line is never evicted.
- R9: A lock request that misses fills the line like a fetch, with `resp_valid` held at 0. It then locks that line.
- R10: When all four ways of a set are locked, a fetch miss is still burst-filled and forwarded, but no line is replaced. A repeat fetch misses again.
- R11: `ctl_op`=10 (unlock) on a hitting address clears the lock, and that line can be evicted again.
- R12: `ctl_op`=11 invalidates every line, clears every lock and restores the reset LRU order.
- R13: While `req_ready` is 1 and `ctl_valid` is 1, the fetch input is ignored: `resp_valid` stays 0 and no fill starts. `ctl_op`=00 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch request |
| req_addr | input | AW | Fetch byte address |
| req_ready | output | 1 | Cache idle, accepting fetch or control |
| resp_valid | output | 1 | Fetch word valid this cycle |
| resp_data | output | DW | Fetched instruction word |
| ctl_valid | input | 1 | Control request, priority over fetch |
| ctl_op | input | 2 | 00 none, 01 lock, 10 unlock, 11 invalidate all |
| ctl_addr | input | AW | Address for lock or unlock |
| mem_req | output | 1 | Burst fill in progress |
| mem_addr | output | AW | Critical word address of the burst |
| mem_rvalid | input | 1 | Burst beat valid |
| mem_rdata | input | DW | Burst beat data |

## Verification
On every cycle, the assertions check the memory port's burst shape: the address holds steady, the beat count is bounded, `mem_req` drops after the fourth beat, and `req_ready` returns. They also check that forwarding happens only on the first beat, that a fetch miss always opens a fill, and that a control request always suppresses the fetch response. Victim order, lock retention, the all-locked bypass and the effects of invalidation depend on the history of each set. Only the bench's scenarios show these, by replaying address sequences whose eviction outcomes are worked out in advance and then probing with hits and misses.

// File: rtl/icache_pkg.sv
package icache_pkg;

   typedef enum logic [1:0] {
      CTL_NONE   = 2'b00,
      CTL_LOCK   = 2'b01,
      CTL_UNLOCK = 2'b10,
      CTL_INVAL  = 2'b11
   } ctl_op_e;

   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_FILL = 1'b1
   } fill_state_e;

endpackage

// File: rtl/icache_way.sv
// One way: tag, valid, lock and data storage with a combinational lookup.
module icache_way #(
   parameter int TAG_W = 20,
   parameter int IDX_W = 8,
   parameter int WRD_W = 2,
   parameter int DW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inv_all,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   input  logic [WRD_W-1:0] rd_word,
   output logic             hit,
   output logic             locked,
   output logic [DW-1:0]    rd_data,
   input  logic             data_we,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WRD_W-1:0] wr_word,
   input  logic [DW-1:0]    wr_data,
   input  logic             line_we,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             lock_we,
   input  logic [IDX_W-1:0] lock_idx,
   input  logic             lock_val
);
   localparam int NSETS = 1 << IDX_W;
   localparam int WPL   = 1 << WRD_W;

   logic [TAG_W-1:0] tag_q [NSETS];
   logic [DW-1:0]    dat_q [NSETS*WPL];
   logic [NSETS-1:0] vld_q;
   logic [NSETS-1:0] lck_q;

   always_ff @(posedge clk) begin
      if (data_we) dat_q[{wr_idx, wr_word}] <= wr_data;
      if (line_we) tag_q[wr_idx] <= wr_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         lck_q <= '0;
      end else if (inv_all) begin
         vld_q <= '0;
         lck_q <= '0;
      end else begin
         if (line_we) vld_q[wr_idx] <= 1'b1;
         if (lock_we) lck_q[lock_idx] <= lock_val;
      end
   end

   assign hit     = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign locked  = lck_q[rd_idx];
   assign rd_data = dat_q[{rd_idx, rd_word}];

endmodule

// File: rtl/icache_lru.sv
// True-LRU age ranks per set; victim = oldest unlocked way.
module icache_lru #(
   parameter int WAYS  = 4,
   parameter int IDX_W = 8,
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inv_all,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [WAYS-1:0]  lock_vec,
   output logic [WAY_W-1:0] victim,
   output logic             victim_ok,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   input  logic [WAY_W-1:0] touch_way
);
   localparam int NSETS = 1 << IDX_W;

   // rank 0 = most recent, WAYS-1 = least recent
   logic [WAY_W-1:0] age_q [NSETS][WAYS];
   logic [WAY_W-1:0] best;
   logic [WAY_W-1:0] ref_age;

   assign ref_age = age_q[touch_idx][touch_way];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= WAY_W'(WAYS - 1 - w);
      end else if (inv_all) begin
         for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= WAY_W'(WAYS - 1 - w);
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
               age_q[touch_idx][w] <= '0;
            else if (age_q[touch_idx][w] < ref_age)
               age_q[touch_idx][w] <= age_q[touch_idx][w] + 1'b1;
         end
      end
   end

   always_comb begin
      victim    = '0;
      victim_ok = 1'b0;
      best      = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!lock_vec[w] && (!victim_ok || age_q[rd_idx][w] > best)) begin
            victim    = WAY_W'(w);
            best      = age_q[rd_idx][w];
            victim_ok = 1'b1;
         end
      end
   end

endmodule

// File: rtl/icache_fill.sv
// Burst fill sequencer: critical word first, wrapping within the line.
module icache_fill
   import icache_pkg::*;
#(
   parameter int AW    = 32,
   parameter int TAG_W = 20,
   parameter int IDX_W = 8,
   parameter int WRD_W = 2,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [TAG_W-1:0] st_tag,
   input  logic [IDX_W-1:0] st_idx,
   input  logic [WRD_W-1:0] st_word,
   input  logic [WAY_W-1:0] st_way,
   input  logic             st_alloc,
   input  logic             st_lock,
   input  logic             st_fwd,
   input  logic             mem_rvalid,
   output logic             busy,
   output logic [AW-1:0]    mem_addr,
   output logic             beat_we,
   output logic [WRD_W-1:0] beat_word,
   output logic             first_beat,
   output logic             last_beat,
   output logic [TAG_W-1:0] f_tag,
   output logic [IDX_W-1:0] f_idx,
   output logic [WAY_W-1:0] f_way,
   output logic             f_alloc,
   output logic             f_lock,
   output logic             f_fwd
);
   fill_state_e      state_q;
   logic [WRD_W-1:0] crit_q;
   logic [WRD_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         cnt_q   <= '0;
         crit_q  <= '0;
         f_tag   <= '0;
         f_idx   <= '0;
         f_way   <= '0;
         f_alloc <= 1'b0;
         f_lock  <= 1'b0;
         f_fwd   <= 1'b0;
      end else if (state_q == FS_IDLE) begin
         if (start) begin
            state_q <= FS_FILL;
            cnt_q   <= '0;
            crit_q  <= st_word;
            f_tag   <= st_tag;
            f_idx   <= st_idx;
            f_way   <= st_way;
            f_alloc <= st_alloc;
            f_lock  <= st_lock;
            f_fwd   <= st_fwd;
         end
      end else if (mem_rvalid) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == '1) state_q <= FS_IDLE;
      end
   end

   assign busy       = (state_q == FS_FILL);
   assign beat_we    = busy && mem_rvalid;
   assign beat_word  = crit_q + cnt_q;
   assign first_beat = beat_we && (cnt_q == '0);
   assign last_beat  = beat_we && (cnt_q == '1);
   assign mem_addr   = {f_tag, f_idx, crit_q, 2'b00};

endmodule

// File: rtl/icache_lock4.sv
module icache_lock4
   import icache_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int WAYS       = 4,
   parameter int SETS       = 256,
   parameter int LINE_WORDS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   output logic          req_ready,
   output logic          resp_valid,
   output logic [DW-1:0] resp_data,
   input  logic          ctl_valid,
   input  logic [1:0]    ctl_op,
   input  logic [AW-1:0] ctl_addr,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata
);
   localparam int IDX_W = $clog2(SETS);
   localparam int WRD_W = $clog2(LINE_WORDS);
   localparam int OFF_W = WRD_W + 2;
   localparam int TAG_W = AW - OFF_W - IDX_W;
   localparam int WAY_W = $clog2(WAYS);

   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_chk_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_chk_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_chk_line
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (DW != 32) begin : g_chk_dw
      $error("DW must be 32: byte offset assumes 4-byte words");
   end
   if (TAG_W < 1) begin : g_chk_tag
      $error("AW too small for the chosen geometry");
   end

   ctl_op_e          op;
   logic [AW-1:0]    lk_addr;
   logic [TAG_W-1:0] lk_tag;
   logic [IDX_W-1:0] lk_idx;
   logic [WRD_W-1:0] lk_word;
   logic [WAYS-1:0]  hit_vec;
   logic [WAYS-1:0]  lck_vec;
   logic [DW-1:0]    rdata [WAYS];
   logic [WAY_W-1:0] hit_way;
   logic [DW-1:0]    hit_data;
   logic             any_hit;

   logic             busy, idle;
   logic             fetch_go, ctl_go, fetch_hit;
   logic             ctl_lock, ctl_unlock, inv_all;
   logic             start;
   logic [WAY_W-1:0] victim;
   logic             victim_ok;

   logic             beat_we, first_beat, last_beat;
   logic [WRD_W-1:0] beat_word;
   logic [TAG_W-1:0] f_tag;
   logic [IDX_W-1:0] f_idx;
   logic [WAY_W-1:0] f_way;
   logic             f_alloc, f_lock, f_fwd;

   logic             touch_en;
   logic [IDX_W-1:0] touch_idx;
   logic [WAY_W-1:0] touch_way;
   logic [IDX_W-1:0] lock_idx;
   logic             lock_val;

   assign op      = ctl_op_e'(ctl_op);
   assign lk_addr = ctl_valid ? ctl_addr : req_addr;
   assign lk_tag  = lk_addr[AW-1 -: TAG_W];
   assign lk_idx  = lk_addr[OFF_W +: IDX_W];
   assign lk_word = lk_addr[2 +: WRD_W];

   assign idle       = !busy;
   assign fetch_go   = idle && req_valid && !ctl_valid;
   assign ctl_go     = idle && ctl_valid;
   assign ctl_lock   = ctl_go && (op == CTL_LOCK);
   assign ctl_unlock = ctl_go && (op == CTL_UNLOCK);
   assign inv_all    = ctl_go && (op == CTL_INVAL);
   assign any_hit    = |hit_vec;
   assign fetch_hit  = fetch_go && any_hit;
   assign start      = (fetch_go && !any_hit) || (ctl_lock && !any_hit && victim_ok);

   always_comb begin
      hit_way  = '0;
      hit_data = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) begin
            hit_way  = WAY_W'(w);
            hit_data = rdata[w];
         end
      end
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic fill_sel;
      assign fill_sel = f_alloc && (f_way == WAY_W'(w));

      icache_way #(
         .TAG_W (TAG_W),
         .IDX_W (IDX_W),
         .WRD_W (WRD_W),
         .DW    (DW)
      ) u_way (
         .clk      (clk),
         .rst_n    (rst_n),
         .inv_all  (inv_all),
         .rd_idx   (lk_idx),
         .rd_tag   (lk_tag),
         .rd_word  (lk_word),
         .hit      (hit_vec[w]),
         .locked   (lck_vec[w]),
         .rd_data  (rdata[w]),
         .data_we  (beat_we && fill_sel),
         .wr_idx   (f_idx),
         .wr_word  (beat_word),
         .wr_data  (mem_rdata),
         .line_we  (last_beat && fill_sel),
         .wr_tag   (f_tag),
         .lock_we  (((ctl_lock || ctl_unlock) && hit_vec[w]) ||
                    (last_beat && fill_sel && f_lock)),
         .lock_idx (lock_idx),
         .lock_val (lock_val)
      );
   end

   assign lock_idx = busy ? f_idx : lk_idx;
   assign lock_val = busy ? 1'b1 : ctl_lock;

   assign touch_en  = fetch_hit || (last_beat && f_alloc);
   assign touch_idx = busy ? f_idx : lk_idx;
   assign touch_way = busy ? f_way : hit_way;

   icache_lru #(
      .WAYS  (WAYS),
      .IDX_W (IDX_W),
      .WAY_W (WAY_W)
   ) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .inv_all   (inv_all),
      .rd_idx    (lk_idx),
      .lock_vec  (lck_vec),
      .victim    (victim),
      .victim_ok (victim_ok),
      .touch_en  (touch_en),
      .touch_idx (touch_idx),
      .touch_way (touch_way)
   );

   icache_fill #(
      .AW    (AW),
      .TAG_W (TAG_W),
      .IDX_W (IDX_W),
      .WRD_W (WRD_W),
      .WAY_W (WAY_W)
   ) u_fill (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .st_tag     (lk_tag),
      .st_idx     (lk_idx),
      .st_word    (lk_word),
      .st_way     (victim),
      .st_alloc   (victim_ok),
      .st_lock    (ctl_go),
      .st_fwd     (fetch_go),
      .mem_rvalid (mem_rvalid),
      .busy       (busy),
      .mem_addr   (mem_addr),
      .beat_we    (beat_we),
      .beat_word  (beat_word),
      .first_beat (first_beat),
      .last_beat  (last_beat),
      .f_tag      (f_tag),
      .f_idx      (f_idx),
      .f_way      (f_way),
      .f_alloc    (f_alloc),
      .f_lock     (f_lock),
      .f_fwd      (f_fwd)
   );

   assign req_ready  = idle;
   assign mem_req    = busy;
   assign resp_valid = fetch_hit || (first_beat && f_fwd);
   assign resp_data  = fetch_hit ? hit_data : mem_rdata;

endmodule

// File: rtl/icache_lock4_chk.sv
module icache_lock4_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          resp_valid,
   input logic          ctl_valid,
   input logic          mem_req,
   input logic [AW-1:0] mem_addr,
   input logic          mem_rvalid
);
   logic [2:0] beats_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          beats_q <= '0;
      else if (!mem_req)   beats_q <= '0;
      else if (mem_rvalid) beats_q <= beats_q + 1'b1;
   end

   p_hit_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && resp_valid) |-> req_valid);

   p_ready_no_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req);

   p_miss_opens_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid && !ctl_valid && !resp_valid) |=> mem_req);

   p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !(mem_rvalid && beats_q == 3'd3)) |=> (mem_req && $stable(mem_addr)));

   p_beats_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (beats_q < 3'd4));

   p_fwd_first_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && resp_valid) |-> (mem_rvalid && beats_q == 3'd0));

   p_fill_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_rvalid && beats_q == 3'd3) |=> (!mem_req && req_ready));

   p_ctl_blocks_fetch_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && ctl_valid) |-> !resp_valid);

endmodule

bind icache_lock4 icache_lock4_chk #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .resp_valid (resp_valid),
   .ctl_valid  (ctl_valid),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_rvalid (mem_rvalid)
);

// File: tb/icache_lock4_bench.sv
`timescale 1ns/1ps
module icache_lock4_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_ready;
   logic        resp_valid;
   logic [31:0] resp_data;
   logic        ctl_valid = 1'b0;
   logic [1:0]  ctl_op = 2'b00;
   logic [31:0] ctl_addr = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   icache_lock4 u_icache_lock4 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
      .ctl_valid(ctl_valid), .ctl_op(ctl_op), .ctl_addr(ctl_addr),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata)
   );

   // {expect_hit, address}; set 0x05 unless noted
   localparam logic [32:0] VEC [16] = '{
      {1'b0, 32'h0000_1054}, {1'b1, 32'h0000_1050}, {1'b1, 32'h0000_105C},
      {1'b1, 32'h0000_1058}, {1'b0, 32'h0000_2050}, {1'b0, 32'h0000_3058},
      {1'b0, 32'h0000_405C}, {1'b1, 32'h0000_1054}, {1'b0, 32'h0000_5050},
      {1'b0, 32'h0000_2050}, {1'b1, 32'h0000_1050}, {1'b1, 32'h0000_4050},
      {1'b0, 32'h0000_3050}, {1'b0, 32'h0000_5050}, {1'b0, 32'h0000_0ABC},
      {1'b1, 32'h0000_0AB0}
   };

   function automatic logic [31:0] memf(input logic [31:0] a);
      return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h1234_5678;
   endfunction

   function automatic logic [31:0] la(input int tag, input int wd);
      return {tag[19:0], 8'h09, wd[1:0], 2'b00};
   endfunction

   task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic serve_fill(input logic [31:0] a, input bit fwd, input string rq);
      @(negedge clk);
      check(mem_req && !req_ready, {rq, " R3 fill open"}, {30'd0, mem_req, req_ready}, 32'h2);
      check(mem_addr == {a[31:2], 2'b00}, {rq, " R3 critical addr"}, mem_addr, {a[31:2], 2'b00});
      for (int b = 0; b < 4; b++) begin
         logic [1:0] wd;
         wd = a[3:2] + 2'(b);
         mem_rvalid = 1'b1;
         mem_rdata  = memf({a[31:4], wd, 2'b00});
         #1;
         if (b == 0 && fwd)
            check(resp_valid && resp_data == memf(a), {rq, " R5 forward"}, resp_data, memf(a));
         else
            check(!resp_valid, {rq, " R5 quiet beat"}, {31'd0, resp_valid}, 32'd0);
         @(posedge clk);
         #1;
      end
      mem_rvalid = 1'b0;
      @(negedge clk);
      check(!mem_req && req_ready, {rq, " R6 fill closed"}, {30'd0, mem_req, req_ready}, 32'h1);
   endtask

   task automatic fetch(input logic [31:0] a, input bit exp_hit, input string rq);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      #1;
      if (exp_hit)
         check(resp_valid && resp_data == memf(a), {rq, " R2 hit"}, resp_data, memf(a));
      else
         check(!resp_valid, {rq, " R3 miss silent"}, {31'd0, resp_valid}, 32'd0);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      if (!exp_hit) serve_fill(a, 1'b1, rq);
   endtask

   task automatic ctl(input logic [1:0] o, input logic [31:0] a);
      @(negedge clk);
      ctl_valid = 1'b1;
      ctl_op    = o;
      ctl_addr  = a;
      @(posedge clk);
      #1;
      ctl_valid = 1'b0;
      ctl_op    = 2'b00;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready && !mem_req && !resp_valid, "R1 reset outputs",
            {29'd0, req_ready, mem_req, resp_valid}, 32'h4);

      // table: R2 R4 R7 hit/miss pattern, eviction by LRU
      foreach (VEC[i]) fetch(VEC[i][31:0], VEC[i][32], $sformatf("R7 vec%0d", i));

      // R13: control has priority, op 00 inert
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h0000_1050;
      ctl_valid = 1'b1; ctl_op = 2'b00; ctl_addr = 32'h0000_1050;
      #1;
      check(!resp_valid, "R13 fetch ignored", {31'd0, resp_valid}, 32'd0);
      @(posedge clk); #1;
      req_valid = 1'b0; ctl_valid = 1'b0;
      @(negedge clk);
      check(req_ready && !mem_req, "R13 no fill", {30'd0, req_ready, mem_req}, 32'h2);
      fetch(32'h0000_1050, 1'b1, "R13 op00 no effect");

      // locking in set 0x09
      fetch(la(1, 0), 1'b0, "R8 setup");
      fetch(la(2, 1), 1'b0, "R8 setup");
      fetch(la(3, 2), 1'b0, "R8 setup");
      ctl(2'b01, la(1, 0));
      @(negedge clk);
      check(req_ready && !mem_req, "R8 lock hit one cycle", {30'd0, req_ready, mem_req}, 32'h2);
      ctl(2'b01, la(7, 2));
      serve_fill(la(7, 2), 1'b0, "R9 lock miss");
      fetch(la(7, 1), 1'b1, "R9 filled line");
      fetch(la(8, 0), 1'b0, "R8 evict unlocked");
      fetch(la(1, 3), 1'b1, "R8 locked kept");
      fetch(la(7, 0), 1'b1, "R9 locked kept");
      fetch(la(2, 0), 1'b0, "R7 evicted earlier");
      ctl(2'b01, la(8, 0));
      ctl(2'b01, la(2, 0));
      fetch(la(3, 1), 1'b0, "R10 bypass");
      fetch(la(3, 1), 1'b0, "R10 no alloc");
      fetch(la(1, 0), 1'b1, "R10 lock held");
      fetch(la(7, 3), 1'b1, "R10 lock held");
      fetch(la(8, 2), 1'b1, "R10 lock held");
      fetch(la(2, 1), 1'b1, "R10 lock held");
      ctl(2'b10, la(8, 0));
      fetch(la(3, 0), 1'b0, "R11 realloc");
      fetch(la(3, 3), 1'b1, "R11 new line");
      fetch(la(8, 0), 1'b0, "R11 unlocked evicted");
      fetch(la(2, 2), 1'b1, "R11 other lock");

      // R12 invalidate all
      ctl(2'b11, 32'd0);
      fetch(32'h0000_1050, 1'b0, "R12 line dropped");
      for (int t = 1; t <= 5; t++) fetch(la(t, 0), 1'b0, "R12 refill");
      fetch(la(1, 0), 1'b0, "R12 lock cleared");
      fetch(la(5, 1), 1'b1, "R12 refilled");

      repeat (2) @(negedge clk);
      finish_up();
   end

endmodule